// File: doc/BRIEF.md
# Serial Register Access Slave with Burst

This block lets an external host reach a bank of 128 eight-bit control registers through a four-wire serial link made of an active-low select, a serial clock, a data input and a data output. Every access opens with a header byte: a direction flag in the most significant position, followed by a 7-bit register address. Data bytes follow the header. While select stays low, each further byte goes to the next address up, so one header opens a burst of any length.

The serial lines are oversampled in a fast system clock through synchronizer flops and edge detectors, so the slave runs entirely in the system domain. On the register side the block offers a generic register-file port. A write appears as a one-cycle strobe carrying address and data. A read appears as a one-cycle request carrying an address, and the register file must answer combinationally in that same cycle. A read burst fetches the next register as soon as the current byte has been received, so that its first bit is ready on the next falling clock edge.

Top module: `spi_regslave`

## Requirements
- R1: A frame is sent most significant bit first. It holds one direction bit, then 7 address bits, then 8 data bits per byte. A completed write byte gives exactly one `wr_en_o` pulse of one system cycle, carrying the address and the byte. `wr_en_o` and `rd_en_o` are never high together.
- R2: A direction bit of 1 selects a write and 0 selects a read. Once the eighth header bit of a read is received, `rd_en_o` pulses with `rd_addr_o` equal to the address in the header, and `rd_data_i` is sampled in that same cycle.
- R3: During a read, the bits on `mosi_i` after the header have no effect and cause no write. The addressed register appears on `miso_o` starting with bit 7 on the first falling SCLK edge after the header, then one bit per falling edge down to bit 0. `miso_o` changes only on a falling SCLK edge or when select is released.
- R4: In a write burst, each completed data byte goes to the address one higher than the byte before it.
- R5: In a read burst, each further byte read out is the register one address higher than the previous one.
- R6: In a burst the address wraps from 7Fh to 00h.
- R7: After bit 0 of a read, `miso_o` keeps that bit until the next falling SCLK edge. `miso_o` is high while select is high, and it is also high during a header and during write data.
- R8: Releasing select partway through a byte drops that byte, performs no write, and restarts the bit count, so the next frame is decoded correctly.
- R9: After reset `miso_o` is high and neither strobe is active. SDI is sampled on the synchronized rising SCLK edge, and each SCLK phase must last at least four system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low select from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register address of the write |
| wr_data_o | output | 8 | Data of the write |
| rd_en_o | output | 1 | One-cycle register read request |
| rd_addr_o | output | 7 | Register address of the read |
| rd_data_i | input | 8 | Read data, valid in the cycle of the request |

## Verification
If the bit counter or phase goes wrong, the next write strobe lands on a shifted address or data byte. The scoreboard, which holds exactly the writes it expects, catches that within the same frame. A wrong burst address shows on the next strobe or the next read byte. A corrupt output shifter shows on the serial line within one bit time, which the host-side sampling compares against an independently kept copy of the registers. An abort that leaks a write appears as an unexpected strobe, and also as a changed register on the following read.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;
  typedef enum logic {PH_HDR = 1'b0, PH_DATA = 1'b1} phase_t;
endpackage

// File: rtl/spi_regslave_sync.sv
module spi_regslave_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic sel_o,
  output logic mosi_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclk_q, csn_q, mosi_q;
  logic          sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      csn_q  <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[LAST-1:0], sclk_i};
      csn_q  <= {csn_q[LAST-1:0], csn_i};
      mosi_q <= {mosi_q[LAST-1:0], mosi_i};
      sclk_d <= sclk_q[LAST];
    end
  end

  assign sclk_rise_o = sclk_q[LAST] & ~sclk_d;
  assign sclk_fall_o = ~sclk_q[LAST] & sclk_d;
  assign sel_o       = ~csn_q[LAST];
  assign mosi_o      = mosi_q[LAST];
endmodule

// File: rtl/spi_regslave_ctrl.sv
module spi_regslave_ctrl
  import spi_regslave_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rise_i,
  input  logic              mosi_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int HDR_BITS = ADDR_W + 1;
  localparam int MAX_BITS = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
  localparam int CNT_W    = $clog2(MAX_BITS);

  phase_t              phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [MAX_BITS-1:0] sh_q, sh_nxt;
  logic [ADDR_W-1:0]   addr_q;
  logic                is_wr_q;
  logic [CNT_W-1:0]    last_idx;
  logic                byte_done;

  assign sh_nxt    = {sh_q[MAX_BITS-2:0], mosi_i};
  assign last_idx  = (phase_q == PH_HDR) ? CNT_W'(HDR_BITS - 1) : CNT_W'(DATA_W - 1);
  assign byte_done = rise_i && (cnt_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_HDR;
      cnt_q     <= '0;
      sh_q      <= '0;
      addr_q    <= '0;
      is_wr_q   <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      rd_en_o <= 1'b0;
      if (!sel_i) begin
        // deselect drops any partial byte
        phase_q <= PH_HDR;
        cnt_q   <= '0;
      end else if (rise_i) begin
        sh_q  <= sh_nxt;
        cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
        if (byte_done) begin
          if (phase_q == PH_HDR) begin
            phase_q <= PH_DATA;
            is_wr_q <= sh_nxt[HDR_BITS-1];
            addr_q  <= sh_nxt[ADDR_W-1:0];
            if (!sh_nxt[HDR_BITS-1]) begin
              rd_en_o   <= 1'b1;
              rd_addr_o <= sh_nxt[ADDR_W-1:0];
            end
          end else begin
            addr_q <= addr_q + 1'b1;
            if (is_wr_q) begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= addr_q;
              wr_data_o <= sh_nxt[DATA_W-1:0];
            end else begin
              // prefetch next register of the burst
              rd_en_o   <= 1'b1;
              rd_addr_o <= addr_q + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_regslave_txshift.sv
module spi_regslave_txshift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              fall_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              miso_o
);
  logic [DATA_W-1:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '1;
      miso_o <= 1'b1;
    end else if (!sel_i) begin
      tx_q   <= '1;
      miso_o <= 1'b1;
    end else begin
      if (load_i) begin
        tx_q <= load_data_i;
      end else if (fall_i) begin
        miso_o <= tx_q[DATA_W-1];
        tx_q   <= {tx_q[DATA_W-2:0], 1'b1};
      end
    end
  end
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  logic sclk_rise, sclk_fall, sel, mosi_s;

  spi_regslave_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .csn_i      (csn_i),
    .mosi_i     (mosi_i),
    .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall),
    .sel_o      (sel),
    .mosi_o     (mosi_s)
  );

  spi_regslave_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel),
    .rise_i   (sclk_rise),
    .mosi_i   (mosi_s),
    .wr_en_o  (wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o),
    .rd_en_o  (rd_en_o),
    .rd_addr_o(rd_addr_o)
  );

  spi_regslave_txshift #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .fall_i     (sclk_fall),
    .load_i     (rd_en_o),
    .load_data_i(rd_data_i),
    .miso_o     (miso_o)
  );
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              sclk_rise_i,
  input logic              sclk_fall_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              rd_en_i,
  input logic              miso_i
);
  logic [ADDR_W-1:0] last_wa_q;
  logic              wa_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_wa_q  <= '0;
      wa_valid_q <= 1'b0;
    end else if (!sel_i) begin
      wa_valid_q <= 1'b0;
    end else if (wr_en_i) begin
      last_wa_q  <= wr_addr_i;
      wa_valid_q <= 1'b1;
    end
  end

  // R1
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_i, rd_en_i}));

  // R2
  wr_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ($past(sclk_rise_i) && $past(sel_i)));

  // R2
  rd_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> ($past(sclk_rise_i) && $past(sel_i)));

  // R3
  miso_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miso_i != $past(miso_i)) |-> ($past(sclk_fall_i) || !$past(sel_i)));

  // R7
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sel_i) |-> miso_i);

  // R4 R6
  burst_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wa_valid_q) |-> (wr_addr_i == ADDR_W'(last_wa_q + 1'b1)));
endmodule

bind spi_regslave spi_regslave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel),
  .sclk_rise_i(sclk_rise),
  .sclk_fall_i(sclk_fall),
  .wr_en_i    (wr_en_o),
  .wr_addr_i  (wr_addr_o),
  .rd_en_i    (rd_en_o),
  .miso_i     (miso_o)
);

// File: tb/spi_regslave_bench.sv
module spi_regslave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso, wr_en, rd_en;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  logic [7:0]  reg_mem [128];
  logic [7:0]  exp_mem [128];
  logic [14:0] wq [$];
  logic [7:0]  txb [8];
  logic [7:0]  rxb [8];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regslave u_spi_regslave (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  assign rd_data = reg_mem[rd_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // register file model and write monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) reg_mem[i] = 8'(i * 7 + 3);
    end else if (wr_en) begin
      if (wq.size() == 0) begin
        chk(1'b0, "R1/R8 unexpected write", {wr_addr, wr_data}, 0);
      end else begin
        logic [14:0] e;
        e = wq.pop_front();
        chk({wr_addr, wr_data} == e, "R1 R4 write strobe", {wr_addr, wr_data}, e);
      end
      reg_mem[wr_addr] = wr_data;
    end
  end

  task automatic spi_bit(input logic b, output logic r);
    mosi = b;
    repeat (HALF) @(negedge clk);
    r = miso;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spi_bit(b[i], r[i]);
  endtask

  task automatic xfer(input logic is_wr, input logic [6:0] a, input int n, input string req);
    logic [7:0] hr;
    if (is_wr)
      for (int i = 0; i < n; i++) begin
        wq.push_back({7'(a + i), txb[i]});
        exp_mem[7'(a + i)] = txb[i];
      end
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_byte({is_wr, a}, hr);
    chk(hr == 8'hFF, "R7 miso high in header", hr, 8'hFF);
    for (int i = 0; i < n; i++) spi_byte(txb[i], rxb[i]);
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (is_wr) chk(rxb[i] == 8'hFF, "R7 miso high in write", rxb[i], 8'hFF);
      else chk(rxb[i] == exp_mem[7'(a + i)], req, rxb[i], exp_mem[7'(a + i)]);
    end
  endtask

  initial begin
    logic [7:0] r;
    logic       hold;
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(miso == 1'b1, "R9 reset miso", miso, 1);
    chk(!wr_en && !rd_en, "R9 reset strobes", {wr_en, rd_en}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 single write then read back
    txb[0] = 8'hA5;
    xfer(1'b1, 7'h05, 1, "R1");
    xfer(1'b0, 7'h05, 1, "R2 single read");
    // R3 data bits during read ignored
    txb[0] = 8'hFF;
    xfer(1'b0, 7'h10, 1, "R3 read with sdi ones");
    txb[0] = 8'h00;
    xfer(1'b0, 7'h10, 1, "R3 register unchanged");
    // R4 burst write, R5 burst read
    txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33; txb[3] = 8'hC4;
    xfer(1'b1, 7'h20, 4, "R4");
    txb[0] = 8'h00; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
    xfer(1'b0, 7'h20, 4, "R5 burst read");
    // R6 wrap
    txb[0] = 8'h7E; txb[1] = 8'h7F; txb[2] = 8'h80;
    xfer(1'b1, 7'h7E, 3, "R6");
    xfer(1'b0, 7'h7F, 2, "R6 wrap read");

    // R7 hold last bit, release pulls high
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_byte({1'b0, 7'h21}, r);
    for (int i = 7; i >= 1; i--) spi_bit(1'b1, r[i]);
    repeat (HALF) @(negedge clk);
    r[0] = miso;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    hold = miso;
    chk(r == exp_mem[7'h21], "R7 read data", r, exp_mem[7'h21]);
    chk(hold == exp_mem[7'h21][0], "R7 hold D0", hold, exp_mem[7'h21][0]);
    csn = 1'b1;
    repeat (6) @(negedge clk);
    chk(miso == 1'b1, "R7 release high", miso, 1);
    sclk = 1'b0;
    repeat (2 * HALF) @(negedge clk);

    // R8 abort mid-byte
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_byte({1'b1, 7'h33}, r);
    for (int i = 0; i < 4; i++) spi_bit(1'b1, hold);
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    txb[0] = 8'h00;
    xfer(1'b0, 7'h33, 1, "R8 aborted byte not written");
    txb[0] = 8'h5A;
    xfer(1'b1, 7'h33, 1, "R8");
    xfer(1'b0, 7'h33, 1, "R8 frame after abort");

    repeat (10) @(negedge clk);
    chk(wq.size() == 0, "R1 missing writes", wq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule